// File: doc/BRIEF.md
# Sticky interrupt status controller

This block gathers live out-of-limit flags, one per monitored channel, into two 8-bit status registers. A status bit goes to 1 as soon as its channel reports a fault, and it stays at 1 after the fault goes away. It drops only when software reads the register while that channel is back in limit. Software therefore cannot miss a short excursion between two polls.

Status register 1 holds a summary bit that reports whether anything is pending in status register 2. Two mask registers stop individual sources from pulling the active-low alert line. A masked source still records its status bit. The measurement and limit-compare logic sits upstream and delivers ready condition bits. A serial bus agent upstream turns bus transfers into the simple strobed register port used here.

Each status bit is a small state machine with three states:

| State | Meaning |
|-------|---------|
| ST_CLEAR | No fault recorded. |
| ST_LIVE | The fault is present now. |
| ST_HELD | The fault has gone, but nobody has read the bit yet. |

It has five transitions:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| T_SET | ST_CLEAR | ST_LIVE | The condition is high. |
| T_DROP | ST_LIVE | ST_HELD | The condition is low and there is no read. |
| T_DROP_READ | ST_LIVE | ST_CLEAR | The condition is low in a read cycle. |
| T_REASSERT | ST_HELD | ST_LIVE | The condition is high. |
| T_ACK | ST_HELD | ST_CLEAR | A read with the condition low. |

In every state a high condition leads to ST_LIVE, even in a read cycle.

Top module: `stky_irq_ctrl`

## Requirements
- R1: After reset, both status registers and both mask registers read 0x00 and alert_n is 1.
- R2: A condition bit that is high in cycle t makes its status bit read 1 from cycle t+1 onwards. This holds whether or not a read happens in cycle t.
- R3: A status bit stays 1 after its condition falls, for as long as its register is not read.
- R4: A read returns the register value from before the read. From the next cycle, each bit of that register equals the bit's condition value in the read cycle.
- R5: If a condition is high in the same cycle that its register is read, the status bit stays 1, because the set wins over the clear.
- R6: Bit 7 of status register 1 (address 0x41) reads 1 exactly when any bit of status register 2 (address 0x42) is 1. This bit is not stored and has no mask bit of its own.
- R7: Mask registers sit at 0x74 (for status 1) and 0x75 (for status 2). Only the implemented positions can be written: 0x76 for mask 1 and 0xFE for mask 2. A mask bit set to 1 keeps its source off the alert but does not stop its status bit from setting.
- R8: alert_n is 0 exactly when some status bit is 1 while its mask bit is 0.
- R9: Unused positions read 0: bits 7, 3 and 0 of the stored status 1, and bit 0 of status 2. Condition inputs at those positions are ignored. Writes to the status addresses change nothing.
- R10: Conditions map to status bits at the same positions. In status 1, the live positions are 6 (remote-2 temperature), 5 (local temperature), 4 (remote-1 temperature), 2 (main supply) and 1 (processor supply). In status 2, the live positions are 7 (diode 2 fault), 6 (diode 1 fault), 5 (fan 4 or thermal input), 4, 3 and 2 (fans 3, 2 and 1), and 1 (overtemperature).
- R11: A read clears only bits of the addressed register. Reading status 1 or a mask register leaves status 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; valid in the cycle of rd_en, 0 otherwise |
| cond1 | input | 8 | Live out-of-limit flags for status register 1 |
| cond2 | input | 8 | Live out-of-limit flags for status register 2 |
| alert_n | output | 1 | Active-low alert |

## Verification
The risky overlap is a clearing read and a condition that is high in the same cycle. The set must win, and the read data must still show the value from before the clear. Directed steps read a register while its condition is held high, and also in the very cycle the condition falls. The bench then reads again to see whether the bit survived. Random traffic mixes reads with condition changes often enough to repeat this overlap many times, and a bench model that follows the set-wins rule judges every read.

// File: rtl/stky_pkg.sv
package stky_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_LIVE  = 2'd1,
        ST_HELD  = 2'd2
    } bit_st_e;
endpackage

// File: rtl/stky_bit_fsm.sv
module stky_bit_fsm
    import stky_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic rd_clr_i,
    output logic set_o
);
    bit_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR: if (cond_i) st_d = ST_LIVE;            // T_SET
            ST_LIVE: begin
                if (!cond_i && rd_clr_i)  st_d = ST_CLEAR;   // T_DROP_READ
                else if (!cond_i)         st_d = ST_HELD;    // T_DROP
            end
            ST_HELD: begin
                if (cond_i)        st_d = ST_LIVE;           // T_REASSERT (set wins)
                else if (rd_clr_i) st_d = ST_CLEAR;          // T_ACK
            end
            default: st_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        set_o = (st_q != ST_CLEAR);
    end
endmodule

// File: rtl/stky_bank.sv
module stky_bank
    import stky_pkg::*;
#(
    parameter logic [REG_W-1:0] USED = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cond_i,
    input  logic             rd_clr_i,
    output logic [REG_W-1:0] stat_o
);
    logic [REG_W-1:0] cond_live;

    always_comb cond_live = cond_i & USED;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        stky_bit_fsm u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond_i   (cond_live[i]),
            .rd_clr_i (rd_clr_i),
            .set_o    (stat_o[i])
        );
    end
endmodule

// File: rtl/stky_regif.sv
module stky_regif
    import stky_pkg::*;
#(
    parameter int                AW      = 8,
    parameter logic [AW-1:0]     A_STAT1 = 'h41,
    parameter logic [AW-1:0]     A_STAT2 = 'h42,
    parameter logic [AW-1:0]     A_MASK1 = 'h74,
    parameter logic [AW-1:0]     A_MASK2 = 'h75,
    parameter logic [REG_W-1:0]  USED1   = 'h76,
    parameter logic [REG_W-1:0]  USED2   = 'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] stat1,
    input  logic [REG_W-1:0] stat2,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] mask1,
    output logic [REG_W-1:0] mask2,
    output logic             rd_clr1,
    output logic             rd_clr2
);
    localparam logic [REG_W-1:0] SUM_BIT = {1'b1, {(REG_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask1 <= '0;
            mask2 <= '0;
        end else if (wr_en) begin
            if (addr == A_MASK1) mask1 <= wdata & USED1;
            if (addr == A_MASK2) mask2 <= wdata & USED2;
        end
    end

    always_comb begin
        rd_clr1 = rd_en && (addr == A_STAT1);
        rd_clr2 = rd_en && (addr == A_STAT2);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (1'b1)
                (addr == A_STAT1): rdata = stat1 | ((|stat2) ? SUM_BIT : '0);
                (addr == A_STAT2): rdata = stat2;
                (addr == A_MASK1): rdata = mask1;
                (addr == A_MASK2): rdata = mask2;
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stky_irq_ctrl.sv
module stky_irq_ctrl
    import stky_pkg::*;
#(
    parameter int                AW      = 8,
    parameter logic [AW-1:0]     A_STAT1 = 'h41,
    parameter logic [AW-1:0]     A_STAT2 = 'h42,
    parameter logic [AW-1:0]     A_MASK1 = 'h74,
    parameter logic [AW-1:0]     A_MASK2 = 'h75,
    parameter logic [REG_W-1:0]  USED1   = 'h76,
    parameter logic [REG_W-1:0]  USED2   = 'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [REG_W-1:0] cond1,
    input  logic [REG_W-1:0] cond2,
    output logic             alert_n
);
    logic [REG_W-1:0] stat1, stat2, mask1, mask2;
    logic             rd_clr1, rd_clr2;

    stky_bank #(.USED(USED1)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .cond_i(cond1), .rd_clr_i(rd_clr1), .stat_o(stat1)
    );

    stky_bank #(.USED(USED2)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .cond_i(cond2), .rd_clr_i(rd_clr2), .stat_o(stat2)
    );

    stky_regif #(
        .AW(AW), .A_STAT1(A_STAT1), .A_STAT2(A_STAT2),
        .A_MASK1(A_MASK1), .A_MASK2(A_MASK2), .USED1(USED1), .USED2(USED2)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .stat1(stat1), .stat2(stat2), .rdata(rdata),
        .mask1(mask1), .mask2(mask2), .rd_clr1(rd_clr1), .rd_clr2(rd_clr2)
    );

    always_comb begin
        alert_n = ~|((stat1 & ~mask1) | (stat2 & ~mask2));
    end
endmodule

// File: rtl/stky_irq_ctrl_chk.sv
module stky_irq_ctrl_chk #(
    parameter int            AW      = 8,
    parameter logic [AW-1:0] A_STAT1 = 'h41,
    parameter logic [AW-1:0] A_STAT2 = 'h42,
    parameter logic [AW-1:0] A_MASK1 = 'h74,
    parameter logic [7:0]    USED1   = 'h76,
    parameter logic [7:0]    USED2   = 'hFE
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          rd_en,
    input logic          wr_en,
    input logic [7:0]    wdata,
    input logic [7:0]    rdata,
    input logic [7:0]    cond1,
    input logic [7:0]    cond2,
    input logic          alert_n,
    input logic [7:0]    stat1,
    input logic [7:0]    stat2,
    input logic [7:0]    mask1,
    input logic [7:0]    mask2
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2 R5
    set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((stat1 & $past(cond1 & USED1)) == $past(cond1 & USED1)) &&
                     ((stat2 & $past(cond2 & USED2)) == $past(cond2 & USED2))));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rd_en)) |-> (((stat1 & $past(stat1)) == $past(stat1)) &&
                                        ((stat2 & $past(stat2)) == $past(stat2))));

    // R4
    rd_clear1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rd_en && (addr == A_STAT1))) |-> (stat1 == $past(cond1 & USED1)));

    // R4
    rd_clear2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rd_en && (addr == A_STAT2))) |-> (stat2 == $past(cond2 & USED2)));

    // R11
    other_rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rd_en && (addr == A_STAT2))) |-> ((stat2 & $past(stat2)) == $past(stat2)));

    // R6
    summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_STAT1)) |-> (rdata[7] == (stat2 != 8'h00)));

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1 & ~USED1) == 8'h00) && ((stat2 & ~USED2) == 8'h00));

    // R7
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en && (addr == A_MASK1))) |-> (mask1 == $past(wdata & USED1)));

    // R8
    alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat1 == 8'h00 && stat2 == 8'h00) |-> alert_n);

    // R8
    alert_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask1 == USED1 && mask2 == USED2) |-> alert_n);

    // R8
    alert_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1 != 8'h00) && (mask1 == 8'h00)) |-> !alert_n);
endmodule

bind stky_irq_ctrl stky_irq_ctrl_chk #(
    .AW(AW), .A_STAT1(A_STAT1), .A_STAT2(A_STAT2), .A_MASK1(A_MASK1),
    .USED1(USED1), .USED2(USED2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cond1(cond1), .cond2(cond2), .alert_n(alert_n),
    .stat1(stat1), .stat2(stat2), .mask1(mask1), .mask2(mask2)
);

// File: tb/stky_irq_ctrl_tb.sv
module stky_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A1 = 8'h41, A2 = 8'h42, M1 = 8'h74, M2 = 8'h75;
    localparam logic [7:0] U1 = 8'h76, U2 = 8'hFE;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n, rd_en, wr_en, alert_n;
    logic [7:0] addr, wdata, rdata, cond1, cond2;

    stky_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cond1(cond1), .cond2(cond2), .alert_n(alert_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_s1 = 0, m_s2 = 0, m_m1 = 0, m_m2 = 0;
    logic [7:0] got;

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            A1:      return m_s1 | ((m_s2 != 0) ? 8'h80 : 8'h00);
            A2:      return m_s2;
            M1:      return m_m1;
            M2:      return m_m2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_alert();
        return ((m_s1 & ~m_m1) | (m_s2 & ~m_m2)) == 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] c1, input logic [7:0] c2, input logic rd,
                       input logic wr, input logic [7:0] a, input logic [7:0] wd);
        @(negedge clk);
        cond1 = c1; cond2 = c2; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        #1;
        got = rdata;
        if (rd) chk("R4 R6 R9 read data", rdata, exp_read(a));
        chk("R8 alert", {7'b0, alert_n}, {7'b0, exp_alert()});
        m_s1 = (c1 & U1) | (m_s1 & ((rd && a == A1) ? 8'h00 : 8'hFF));
        m_s2 = (c2 & U2) | (m_s2 & ((rd && a == A2) ? 8'h00 : 8'hFF));
        if (wr && a == M1) m_m1 = wd & U1;
        if (wr && a == M2) m_m2 = wd & U2;
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] c1, c2, a;
        logic [7:0] alist [5];
        void'($urandom(32'h5EED1234));
        alist[0] = A1; alist[1] = A2; alist[2] = M1; alist[3] = M2; alist[4] = 8'h10;
        rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0; cond1 = 0; cond2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 alert_n", {7'b0, alert_n}, 8'h01);
        cyc(0, 0, 1, 0, A1, 0); chk("R1 status1", got, 8'h00);
        cyc(0, 0, 1, 0, A2, 0); chk("R1 status2", got, 8'h00);
        cyc(0, 0, 1, 0, M1, 0); chk("R1 mask1", got, 8'h00);
        cyc(0, 0, 1, 0, M2, 0); chk("R1 mask2", got, 8'h00);

        // R2 R10 set, R3 sticky, R4 clear
        cyc(8'h40, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0); chk("R2 alert after set", {7'b0, alert_n}, 8'h00);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, A1, 0); chk("R3 R10 sticky bit 6", got, 8'h40);
        cyc(0, 0, 1, 0, A1, 0); chk("R4 cleared after read", got, 8'h00);

        // R5 set wins, R6 summary, R11 no cross clear
        cyc(0, 8'h02, 0, 0, 0, 0);
        cyc(0, 8'h02, 1, 0, A2, 0); chk("R5 read while live", got, 8'h02);
        cyc(0, 0, 1, 0, A1, 0);     chk("R6 summary bit", got, 8'h80);
        cyc(0, 0, 1, 0, M2, 0);
        cyc(0, 0, 1, 0, A2, 0);     chk("R5 R11 bit survived", got, 8'h02);
        cyc(0, 0, 1, 0, A2, 0);     chk("R4 status2 cleared", got, 8'h00);

        // R4 read in the cycle the condition falls
        cyc(0, 8'h10, 0, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, A2, 0); chk("R4 pre-clear value", got, 8'h10);
        cyc(0, 0, 1, 0, A2, 0);     chk("R4 fall plus read", got, 8'h00);

        // R9 unused inputs and status writes ignored
        cyc(8'h89, 8'h01, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, A1, 0); chk("R9 unused status1", got, 8'h00);
        chk("R9 alert stays high", {7'b0, alert_n}, 8'h01);
        cyc(0, 0, 1, 0, A2, 0); chk("R9 unused status2", got, 8'h00);
        cyc(0, 0, 0, 1, A1, 8'hFF);
        cyc(0, 0, 1, 0, A1, 0); chk("R9 status write ignored", got, 8'h00);

        // R7 masking, R8 alert
        cyc(0, 0, 0, 1, M1, 8'hFF);
        cyc(0, 0, 1, 0, M1, 0); chk("R7 mask1 readback", got, 8'h76);
        cyc(0, 0, 0, 1, M2, 8'hFF);
        cyc(0, 0, 1, 0, M2, 0); chk("R7 mask2 readback", got, 8'hFE);
        cyc(8'h20, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0); chk("R7 masked no alert", {7'b0, alert_n}, 8'h01);
        cyc(0, 0, 0, 1, M1, 8'h00);
        cyc(0, 0, 0, 0, 0, 0); chk("R8 unmask raises alert", {7'b0, alert_n}, 8'h00);
        cyc(0, 0, 1, 0, A1, 0); chk("R7 masked bit still set", got, 8'h20);
        cyc(0, 0, 0, 0, 0, 0); chk("R8 alert released", {7'b0, alert_n}, 8'h01);
        cyc(0, 0, 0, 1, M2, 8'h00);

        // random traffic: R2 R3 R4 R5 R6 R8 via the model
        c1 = 0; c2 = 0;
        for (int i = 0; i < 4000; i++) begin
            logic rd, wr;
            c1 ^= 8'($urandom & $urandom & $urandom);
            c2 ^= 8'($urandom & $urandom & $urandom);
            rd = ($urandom % 3) == 0;
            wr = !rd && (($urandom % 8) == 0);
            a  = alist[$urandom % 5];
            cyc(c1, c2, rd, wr, a, 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule